// File: doc/BRIEF.md
# Port-Grouped Digital I/O Register Bank

This block is a byte-wide memory-mapped register bank that controls 32 digital pad lines arranged as four 8-bit ports. Software sets the direction of each port as a whole, writes output values into per-port latches and reads back either the live pad level or the latched value. Direction comes from two kinds of register: a shared direction/enable register and two control registers that carry a per-port input-mode bit. A port is driven only when both agree that it is an output and its buffer-disable bit is clear.

The bus side is a simple synchronous interface with address, write strobe, read strobe, write data and registered read data. The pad side exposes a 32-bit input, a 32-bit output value and a 32-bit output enable. The port numbering and the bit positions inside the configuration registers are fixed, because the software above this block decodes them.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset every port is an input: pad_oe is all zero, the direction/enable register (0x82) reads 0x00, both control registers (0x83, 0xC3) read 0x92 and every output latch holds 0x00.
- R2: Writing a port data register (port 0 at 0x80, port 1 at 0x81, port 2 at 0xC0, port 3 at 0xC1) loads that port's output latch in every mode; pad_out always shows the four latches, port 0 in bits 7:0 up to port 3 in bits 31:24.
- R3: In the direction/enable register, bits 2, 3, 6, 7 are the output bits of ports 0, 1, 2, 3 and bits 0, 1, 4, 5 are the buffer-disable bits of ports 0, 1, 2, 3.
- R4: In the control register at 0x83, bit 4 marks port 0 as input and bit 1 marks port 1 as input; the register at 0xC3 uses the same positions for ports 2 and 3; bit 7 is a set bit that is stored and read back.
- R5: All eight lines of a port are output-enabled exactly when its output bit is 1, its input bit is 0 and its buffer-disable bit is 0.
- R6: A set buffer-disable bit removes the output enable of a port even while the port is configured as output.
- R7: Reading a port data register returns the pad input byte when the port is an input (output bit 0 or input bit 1) and the latch when the port is an output, whether or not its buffer is disabled.
- R8: bus_rdata takes the addressed value on the clock edge where bus_rd is high and holds it until the next read; a read and write in the same cycle return the contents from before the write.
- R9: Reads from any offset other than the seven mapped ones return 0x00, and writes to them change no register, latch or pad output.
- R10: The direction/enable and control registers read back the full byte last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 32 | Pad input levels, port 0 in bits 7:0 |
| pad_out | output | 32 | Output latch values toward the pads |
| pad_oe | output | 32 | Per-line output enable, uniform within each port |

## Verification
A read and a write can land in the same cycle, either on the same data register or on a configuration register and a data register whose read mode it changes. The bench issues both strobes together on chosen and on random addresses and expects the read to reflect the register state from before the edge, while the written value must show on the pads and on the next read. The random stream also mixes direction changes with data reads so that the pad-versus-latch choice is judged right after each mode switch.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PORTS   = 4;
    localparam int PORT_W  = 8;
    localparam int BUS_W   = 8;
    localparam int ADDR_W  = 8;
    localparam int PADS    = PORTS * PORT_W;
    localparam int PIDX_W  = $clog2(PORTS);

    localparam logic [ADDR_W-1:0] A_DAT0  = 8'h80;
    localparam logic [ADDR_W-1:0] A_DAT1  = 8'h81;
    localparam logic [ADDR_W-1:0] A_DIR   = 8'h82;
    localparam logic [ADDR_W-1:0] A_CTL01 = 8'h83;
    localparam logic [ADDR_W-1:0] A_DAT2  = 8'hC0;
    localparam logic [ADDR_W-1:0] A_DAT3  = 8'hC1;
    localparam logic [ADDR_W-1:0] A_CTL23 = 8'hC3;

    // control registers come out of reset with both ports in input mode
    localparam logic [BUS_W-1:0] CTL_RST = 8'h92;
    localparam logic [BUS_W-1:0] DIR_RST = 8'h00;

    typedef logic [PORTS-1:0][PORT_W-1:0] latch_arr_t;

    typedef struct packed {
        latch_arr_t       lat;
        logic [BUS_W-1:0] dir;
        logic [BUS_W-1:0] ctl01;
        logic [BUS_W-1:0] ctl23;
        logic [BUS_W-1:0] rdata;
    } bank_state_t;

    function automatic int out_pos(input int p);
        case (p)
            0:       return 2;
            1:       return 3;
            2:       return 6;
            default: return 7;
        endcase
    endfunction

    function automatic int dis_pos(input int p);
        case (p)
            0:       return 0;
            1:       return 1;
            2:       return 4;
            default: return 5;
        endcase
    endfunction

    // even ports use bit 4, odd ports bit 1 of their control register
    function automatic int in_pos(input int p);
        return (p % 2 == 0) ? 4 : 1;
    endfunction

    typedef struct packed {
        logic              hit;
        logic [PIDX_W-1:0] idx;
    } port_sel_t;

    function automatic port_sel_t data_sel(input logic [ADDR_W-1:0] a);
        port_sel_t s;
        s.hit = 1'b1;
        s.idx = '0;
        case (a)
            A_DAT0:  s.idx = 2'd0;
            A_DAT1:  s.idx = 2'd1;
            A_DAT2:  s.idx = 2'd2;
            A_DAT3:  s.idx = 2'd3;
            default: s.hit = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_dir_resolve.sv
module gpio_dir_resolve
    import gpio_bank_pkg::*;
(
    input  logic [BUS_W-1:0] dir_q,
    input  logic [BUS_W-1:0] ctl01_q,
    input  logic [BUS_W-1:0] ctl23_q,
    output logic [PORTS-1:0] port_is_out,
    output logic [PORTS-1:0] port_drive
);

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        localparam int OP = out_pos(p);
        localparam int DP = dis_pos(p);
        localparam int IP = in_pos(p);
        logic in_mode;

        if (p < 2) begin : g_lo
            assign in_mode = ctl01_q[IP];
        end else begin : g_hi
            assign in_mode = ctl23_q[IP];
        end

        assign port_is_out[p] = dir_q[OP] & ~in_mode;
        assign port_drive[p]  = port_is_out[p] & ~dir_q[DP];
    end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_bank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  latch_arr_t        lat_q,
    input  logic [PADS-1:0]   pad_in,
    input  logic [PORTS-1:0]  port_is_out,
    input  logic [BUS_W-1:0]  dir_q,
    input  logic [BUS_W-1:0]  ctl01_q,
    input  logic [BUS_W-1:0]  ctl23_q,
    output logic [BUS_W-1:0]  rd_val
);

    logic [PORTS-1:0][PORT_W-1:0] port_view;

    for (genvar p = 0; p < PORTS; p++) begin : g_view
        assign port_view[p] = port_is_out[p] ? lat_q[p]
                                             : pad_in[p*PORT_W +: PORT_W];
    end

    always_comb begin
        port_sel_t sel;
        sel    = data_sel(addr);
        rd_val = '0;
        if (sel.hit) begin
            rd_val = port_view[sel.idx];
        end else begin
            case (addr)
                A_DIR:   rd_val = dir_q;
                A_CTL01: rd_val = ctl01_q;
                A_CTL23: rd_val = ctl23_q;
                default: rd_val = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [31:0]       pad_in,
    output logic [31:0]       pad_out,
    output logic [31:0]       pad_oe
);

    bank_state_t st_d, st_q;
    logic [PORTS-1:0] port_is_out;
    logic [PORTS-1:0] port_drive;
    logic [BUS_W-1:0] rd_val;

    gpio_dir_resolve u_dir (
        .dir_q       (st_q.dir),
        .ctl01_q     (st_q.ctl01),
        .ctl23_q     (st_q.ctl23),
        .port_is_out (port_is_out),
        .port_drive  (port_drive)
    );

    gpio_read_mux u_rmux (
        .addr        (bus_addr),
        .lat_q       (st_q.lat),
        .pad_in      (pad_in),
        .port_is_out (port_is_out),
        .dir_q       (st_q.dir),
        .ctl01_q     (st_q.ctl01),
        .ctl23_q     (st_q.ctl23),
        .rd_val      (rd_val)
    );

    always_comb begin
        port_sel_t wsel;
        st_d = st_q;
        wsel = data_sel(bus_addr);
        if (bus_wr) begin
            if (wsel.hit) begin
                st_d.lat[wsel.idx] = bus_wdata;
            end else begin
                case (bus_addr)
                    A_DIR:   st_d.dir   = bus_wdata;
                    A_CTL01: st_d.ctl01 = bus_wdata;
                    A_CTL23: st_d.ctl23 = bus_wdata;
                    default: ;
                endcase
            end
        end
        if (bus_rd) begin
            st_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lat   <= '0;
            st_q.dir   <= DIR_RST;
            st_q.ctl01 <= CTL_RST;
            st_q.ctl23 <= CTL_RST;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign pad_out   = st_q.lat;

    for (genvar p = 0; p < PORTS; p++) begin : g_oe
        assign pad_oe[p*PORT_W +: PORT_W] = {PORT_W{port_drive[p]}};
    end

    function automatic logic mapped(input logic [7:0] a);
        return (a == A_DAT0) || (a == A_DAT1) || (a == A_DAT2) || (a == A_DAT3)
            || (a == A_DIR) || (a == A_CTL01) || (a == A_CTL23);
    endfunction

    // R2
    latch0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DAT0) |=> (pad_out[7:0] == $past(bus_wdata)));

    // R6
    dis_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIR && bus_wdata[0]) |=> (pad_oe[7:0] == 8'h00));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped(bus_addr)) |=> (bus_rdata == 8'h00));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped(bus_addr)) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R5
    oe_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[15:8] == 8'h00 || pad_oe[15:8] == 8'hFF));

endmodule

// File: tb/gpio_port_bank_bench.sv
module gpio_port_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // model state
    logic [7:0] m_lat [4];
    logic [7:0] m_dir, m_c01, m_c23, m_rd;

    always #10 clk = ~clk;

    gpio_port_bank u_gpio_port_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit m_in(input int p);
        return (p < 2) ? m_c01[(p % 2 == 0) ? 4 : 1] : m_c23[(p % 2 == 0) ? 4 : 1];
    endfunction

    function automatic bit m_out(input int p);
        int ob;
        ob = (p == 0) ? 2 : (p == 1) ? 3 : (p == 2) ? 6 : 7;
        return m_dir[ob] && !m_in(p);
    endfunction

    function automatic bit m_drv(input int p);
        int db;
        db = (p == 0) ? 0 : (p == 1) ? 1 : (p == 2) ? 4 : 5;
        return m_out(p) && !m_dir[db];
    endfunction

    function automatic int port_of(input logic [7:0] a);
        case (a)
            8'h80: return 0;
            8'h81: return 1;
            8'hC0: return 2;
            8'hC1: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] a, input logic [31:0] pin);
        int p;
        p = port_of(a);
        if (p >= 0) return m_out(p) ? m_lat[p] : pin[p*8 +: 8];
        case (a)
            8'h82: return m_dir;
            8'h83: return m_c01;
            8'hC3: return m_c23;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] m_oe();
        logic [31:0] v;
        for (int p = 0; p < 4; p++) v[p*8 +: 8] = {8{m_drv(p)}};
        return v;
    endfunction

    function automatic logic [31:0] m_pout();
        return {m_lat[3], m_lat[2], m_lat[1], m_lat[0]};
    endfunction

    task automatic model_reset();
        for (int p = 0; p < 4; p++) m_lat[p] = 8'h00;
        m_dir = 8'h00; m_c01 = 8'h92; m_c23 = 8'h92; m_rd = 8'h00;
    endtask

    // one bus cycle; called at a falling edge, returns at the next falling edge
    task automatic op(input bit wr, input bit rd, input logic [7:0] a,
                      input logic [7:0] wd, input logic [31:0] pin, input string req);
        logic [7:0] exp_rd;
        int p;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; pad_in = pin;
        exp_rd = m_read(a, pin);
        @(posedge clk);
        #1;
        if (rd) m_rd = exp_rd;
        if (wr) begin
            p = port_of(a);
            if (p >= 0) m_lat[p] = wd;
            else if (a == 8'h82) m_dir = wd;
            else if (a == 8'h83) m_c01 = wd;
            else if (a == 8'hC3) m_c23 = wd;
        end
        chk({req, " rdata"}, {24'h0, bus_rdata}, {24'h0, m_rd});
        chk({req, " pad_oe"}, pad_oe, m_oe());
        chk({req, " pad_out"}, pad_out, m_pout());
        bus_wr = 1'b0; bus_rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] addrs [7];
        void'($urandom(32'd20250611));
        addrs[0] = 8'h80; addrs[1] = 8'h81; addrs[2] = 8'h82; addrs[3] = 8'h83;
        addrs[4] = 8'hC0; addrs[5] = 8'hC1; addrs[6] = 8'hC3;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 oe", pad_oe, 32'h0);
        chk("R1 out", pad_out, 32'h0);
        op(0, 1, 8'h82, 8'h00, 32'h0, "R1 dir");
        op(0, 1, 8'h83, 8'h00, 32'h0, "R1 ctl01");
        op(0, 1, 8'hC3, 8'h00, 32'h0, "R1 ctl23");
        op(0, 1, 8'h80, 8'h00, 32'hA5C3_3C5A, "R7 input read");

        // R2 latch written while input, takes effect after switch (R3/R4/R5)
        op(1, 0, 8'h81, 8'h6E, 32'h0, "R2 latch p1");
        op(1, 0, 8'hC1, 8'hD2, 32'h0, "R2 latch p3");
        op(1, 0, 8'h83, 8'h90, 32'h0, "R4 p1 in clear");
        op(0, 1, 8'h81, 8'h00, 32'h0000_FF00, "R7 p1 no out bit");
        op(1, 0, 8'h82, 8'h08, 32'h0, "R3 R5 p1 out");
        op(0, 1, 8'h81, 8'h00, 32'h0000_FF00, "R7 p1 latch");
        op(1, 0, 8'hC3, 8'h90, 32'h0, "R4 p3 in clear");
        op(1, 0, 8'h82, 8'h88, 32'h0, "R3 R5 p3 out");
        // R6 buffer disable keeps output read of latch
        op(1, 0, 8'h82, 8'hAA, 32'h0, "R6 p1 p3 disabled");
        op(0, 1, 8'hC1, 8'h00, 32'h1234_5678, "R7 disabled reads latch");
        op(1, 0, 8'h82, 8'h88, 32'h0, "R6 re-enable");
        // R8 same-cycle read and write
        op(1, 1, 8'h81, 8'h11, 32'h0, "R8 rd+wr data");
        op(0, 1, 8'h81, 8'h00, 32'h0, "R8 after write");
        op(1, 1, 8'h82, 8'h00, 32'h0, "R8 rd+wr dir");
        op(0, 0, 8'h00, 8'h00, 32'h0, "R8 hold");
        // R9 unmapped
        op(1, 1, 8'hC2, 8'hFF, 32'hFFFF_FFFF, "R9 C2");
        op(1, 1, 8'h84, 8'hFF, 32'hFFFF_FFFF, "R9 84");
        op(1, 1, 8'h00, 8'hFF, 32'hFFFF_FFFF, "R9 00");
        // R10 full byte readback
        op(1, 0, 8'h83, 8'h5B, 32'h0, "R10 wr ctl01");
        op(0, 1, 8'h83, 8'h00, 32'h0, "R10 rd ctl01");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            int k;
            k = int'($urandom % 10);
            a = (k < 7) ? addrs[k] : 8'($urandom);
            op(bit'($urandom % 2), bit'($urandom % 2), a, 8'($urandom), $urandom,
               "R2 R5 R7 R8 R9 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule